// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a down-counting watchdog for a system-on-chip. Software programs a reload value, enables the count, and must service the watchdog before it runs out. Once enabled, the counter moves down by one on every tick-enable pulse. When a tick finds the counter already at zero, the block raises an interrupt and restarts the count from the reload value. If the count runs out a second time and the interrupt is still pending, the block drives a system reset pulse. Software services the watchdog by writing to the clear register. That one write removes the pending interrupt and restarts the count.

A key register protects every configuration write, so a stray write cannot reconfigure the watchdog or quietly service it. The block uses one clock. The counter advances on a tick-enable strobe, so the timeout base can be slower than the bus clock. The register port is a simple APB-style port: every access finishes in one cycle, with no wait states and no error response.

Top module: `wdog_timer`

## Requirements
- R1: Out of reset the block is unlocked. The control register reads 0, the counter is stopped, and both `irq_o` and `sys_rst_o` are low.
- R2: Writing 0x1ACCE551 to offset 0xC00 unlocks the registers. Writing any other value there locks them. Offset 0xC00 reads 1 when locked and 0 when unlocked.
- R3: While the block is locked, writes to offsets 0x000, 0x008 and 0x00C have no effect.
- R4: A write to offset 0x000 sets the reload value, which reads back from 0x000, and loads it into the counter at once. Offset 0x004 returns the live count at any time.
- R5: In the control register at offset 0x008, bit 0 runs the counter and enables the interrupt, and bit 1 enables the reset output. All other bits read as zero.
- R6: While bit 0 is set, each tick lowers a non-zero count by one. A tick that finds the count at zero is an expiry: it sets the interrupt flag and reloads the count. With reload value L, an expiry occurs every L+1 ticks.
- R7: Any write to offset 0x00C clears the interrupt flag and reloads the counter from the reload value.
- R8: If control bit 1 is set and an expiry occurs while the interrupt flag is set, `sys_rst_o` goes high for exactly RST_CYCLES clock cycles and the flag is cleared. If bit 1 is clear, that expiry only keeps the flag set.
- R9: Bit 0 of offset 0x014 returns the raw interrupt flag whether or not the counter is running. `irq_o` follows the flag while control bit 0 is set.
- R10: While control bit 0 is clear, the count holds its value, and `irq_o` and `sys_rst_o` stay low.
- R11: Reads of offsets outside the map return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter advance strobe |
| bus_sel | input | 1 | Peripheral select |
| bus_en | input | 1 | Access enable |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq_o | output | 1 | Watchdog interrupt |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
Four properties are checked on every cycle:
- the counter steps down by exactly one per tick;
- the first expiry sets the flag;
- a stopped counter holds its value, and a locked write leaves the reload value unchanged;
- a reset pulse only ever follows a visible interrupt, and no pulse appears while the counter is stopped.

Only the bench scenarios show the rest:
- the end-to-end timing, L+1 ticks to the interrupt and another L+1 ticks to reset, across reload values and tick spacings;
- the exact pulse width;
- the key semantics;
- that reserved and unmapped reads return zero.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [11:0] OFS_LOAD  = 12'h000;
  localparam logic [11:0] OFS_COUNT = 12'h004;
  localparam logic [11:0] OFS_CTRL  = 12'h008;
  localparam logic [11:0] OFS_CLEAR = 12'h00C;
  localparam logic [11:0] OFS_STAT  = 12'h014;
  localparam logic [11:0] OFS_LOCK  = 12'hC00;
  localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              flag_i,
  output logic [CNT_W-1:0]  load_o,
  output logic              run_o,
  output logic              arm_o,
  output logic              reload_o,
  output logic [CNT_W-1:0]  reload_val_o,
  output logic              clear_o
);
  logic             locked_q, locked_d;
  logic [CNT_W-1:0] load_q, load_d;
  logic             run_q, run_d, arm_q, arm_d;
  logic             wr_stb, wr_ok;
  logic             hit_load, hit_ctrl, hit_clear, hit_lock;

  assign wr_stb    = bus_sel & bus_en & bus_wr;
  assign wr_ok     = wr_stb & ~locked_q;
  assign hit_load  = bus_addr == ADDR_W'(OFS_LOAD);
  assign hit_ctrl  = bus_addr == ADDR_W'(OFS_CTRL);
  assign hit_clear = bus_addr == ADDR_W'(OFS_CLEAR);
  assign hit_lock  = bus_addr == ADDR_W'(OFS_LOCK);

  always_comb begin
    locked_d = locked_q;
    load_d   = load_q;
    run_d    = run_q;
    arm_d    = arm_q;
    if (wr_stb && hit_lock) locked_d = (bus_wdata != UNLOCK_KEY);
    if (wr_ok && hit_load)  load_d = bus_wdata[CNT_W-1:0];
    if (wr_ok && hit_ctrl) begin
      run_d = bus_wdata[0];
      arm_d = bus_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      load_q   <= '1;
      run_q    <= 1'b0;
      arm_q    <= 1'b0;
    end else begin
      locked_q <= locked_d;
      load_q   <= load_d;
      run_q    <= run_d;
      arm_q    <= arm_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_LOAD))       bus_rdata = 32'(load_q);
    else if (bus_addr == ADDR_W'(OFS_COUNT)) bus_rdata = 32'(cnt_i);
    else if (bus_addr == ADDR_W'(OFS_CTRL))  bus_rdata = {30'b0, arm_q, run_q};
    else if (bus_addr == ADDR_W'(OFS_STAT))  bus_rdata = {31'b0, flag_i};
    else if (bus_addr == ADDR_W'(OFS_LOCK))  bus_rdata = {31'b0, locked_q};
  end

  assign load_o       = load_q;
  assign run_o        = run_q;
  assign arm_o        = arm_q;
  assign reload_o     = wr_ok & hit_load;
  assign reload_val_o = bus_wdata[CNT_W-1:0];
  assign clear_o      = wr_ok & hit_clear;

  // R3: a locked write to the reload register leaves it unchanged
  assert_locked_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q && wr_stb && hit_load |=> $stable(load_o));
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             arm_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             expire;

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    expire = 1'b0;
    fire_o = 1'b0;
    if (reload_i) begin
      cnt_d = reload_val_i;
    end else if (clear_i) begin
      cnt_d  = load_i;
      flag_d = 1'b0;
    end else if (run_i && tick_i) begin
      if (cnt_q == '0) begin
        cnt_d  = load_i;
        expire = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    if (expire) begin
      if (flag_q && arm_i) begin
        fire_o = 1'b1;
        flag_d = 1'b0;
      end else begin
        flag_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  // R6: one tick lowers a non-zero count by exactly one
  assert_tick_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && tick_i && !reload_i && !clear_i && cnt_o != '0 |=> cnt_o == $past(cnt_o) - 1'b1);
  // R6: the first expiry leaves the flag set
  assert_first_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && tick_i && !reload_i && !clear_i && cnt_o == '0 && !flag_o |=> flag_o);
  // R10: a stopped counter holds its value
  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i && !reload_i && !clear_i |=> $stable(cnt_o));
endmodule

// File: rtl/wdog_rstpulse.sv
module wdog_rstpulse #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic fire_i,
  output logic pulse_o
);
  localparam int PW = $clog2(RST_CYCLES + 1);

  logic [PW-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (!run_i)             left_d = '0;
    else if (fire_i)        left_d = PW'(RST_CYCLES);
    else if (left_q != '0)  left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign pulse_o = left_q != '0;

  // R10: no reset pulse in the cycle after the counter is stopped
  assert_stop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !pulse_o);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int CNT_W      = 32,
  parameter int ADDR_W     = 12,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              sys_rst_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [CNT_W-1:0] cnt, load, reload_val;
  logic             flag, run, arm, reload, clear, fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  wdog_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .bus_sel(bus_sel), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_i(cnt), .flag_i(flag),
    .load_o(load), .run_o(run), .arm_o(arm),
    .reload_o(reload), .reload_val_o(reload_val), .clear_o(clear)
  );

  wdog_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_int_n),
    .run_i(run), .arm_i(arm), .tick_i(tick_en),
    .load_i(load), .reload_i(reload), .reload_val_i(reload_val), .clear_i(clear),
    .cnt_o(cnt), .flag_o(flag), .fire_o(fire)
  );

  wdog_rstpulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
    .clk(clk), .rst_n(rst_int_n),
    .run_i(run), .fire_i(fire), .pulse_o(sys_rst_o)
  );

  assign irq_o = flag & run;

  // R8: a reset pulse starts only after the interrupt was visible
  assert_rst_after_irq_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(sys_rst_o) |-> $past(irq_o));
endmodule

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
  localparam int CLK_PERIOD = 10;
  localparam int RSTW = 4;

  logic clk = 1'b0;
  logic rst_n, tick_en, bus_sel, bus_en, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic irq_o, sys_rst_o;
  int checks = 0, errors = 0;
  logic [31:0] rd;
  int n;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_timer #(.CNT_W(32), .ADDR_W(12), .RST_CYCLES(RSTW)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_sel(bus_sel), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .sys_rst_o(sys_rst_o)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_en = 0; bus_wr = 0;
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // tick count until the selected output is seen high (which: 0 irq, 1 reset)
  task automatic ticks_until(input int which, input int period, output int nt);
    int ph = 0;
    nt = 0;
    for (int c = 0; c < 5000; c++) begin
      @(negedge clk);
      if ((which == 0 && irq_o) || (which == 1 && sys_rst_o)) begin
        tick_en = 0;
        return;
      end
      tick_en = (ph % period) == 0;
      ph++;
      if (tick_en) nt++;
    end
    tick_en = 0;
    nt = -1;
  endtask

  task automatic tick_n(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); tick_en = 1;
      @(negedge clk); tick_en = 0;
    end
  endtask

  initial begin
    rst_n = 0; tick_en = 0; bus_sel = 0; bus_en = 0; bus_wr = 0;
    bus_addr = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_reg(12'h008, rd); check(rd, 0, "R1 ctrl");
    rd_reg(12'hC00, rd); check(rd, 0, "R1 lock");
    check({31'b0, irq_o}, 0, "R1 irq");
    check({31'b0, sys_rst_o}, 0, "R1 rst");

    // R5 reserved control bits
    wr(12'h008, 32'hFFFF_FFFC); rd_reg(12'h008, rd); check(rd, 0, "R5 reserved");
    wr(12'h008, 32'h0000_0002); rd_reg(12'h008, rd); check(rd, 2, "R5 bit1");
    wr(12'h008, 0);

    // R11 unmapped
    rd_reg(12'h010, rd); check(rd, 0, "R11 0x010");
    rd_reg(12'h800, rd); check(rd, 0, "R11 0x800");

    // R4 load and live count
    wr(12'h000, 32'hFFFF_FFFF); rd_reg(12'h000, rd); check(rd, 32'hFFFF_FFFF, "R4 max load");
    rd_reg(12'h004, rd); check(rd, 32'hFFFF_FFFF, "R4 max count");
    wr(12'h000, 10); rd_reg(12'h004, rd); check(rd, 10, "R4 reload on write");
    wr(12'h008, 1); tick_n(3);
    rd_reg(12'h004, rd); check(rd, 7, "R6 three ticks");
    wr(12'h008, 0); tick_n(4);
    rd_reg(12'h004, rd); check(rd, 7, "R10 frozen");

    // expiry sweep: reload L, tick spacing p, reset armed
    for (int p = 1; p <= 3; p += 2) begin
      for (int L = 0; L <= 5; L++) begin
        wr(12'h008, 0); wr(12'h000, L); wr(12'h00C, 1); wr(12'h008, 3);
        ticks_until(0, p, n); check(n, L + 1, "R6 first expiry ticks");
        ticks_until(1, p, n); check(n, L + 1, "R8 second expiry ticks");
        n = 1;
        for (int c = 0; c < 50; c++) begin
          @(negedge clk);
          if (!sys_rst_o) break;
          n++;
        end
        check(n, RSTW, "R8 pulse width");
        check({31'b0, irq_o}, 0, "R8 flag cleared");
      end
    end

    // R8 reset disabled: flag persists, no pulse
    wr(12'h008, 0); wr(12'h000, 2); wr(12'h00C, 1); wr(12'h008, 1);
    ticks_until(0, 1, n); check(n, 3, "R6 expiry unarmed");
    ticks_until(1, 1, n); check(n, -1, "R8 no reset when bit1 clear");
    rd_reg(12'h014, rd); check(rd, 1, "R9 status pending");
    check({31'b0, irq_o}, 1, "R9 irq follows flag");

    // R10 stop hides irq, R9 raw status stays
    wr(12'h008, 0);
    check({31'b0, irq_o}, 0, "R10 irq low when stopped");
    rd_reg(12'h014, rd); check(rd, 1, "R9 raw status stopped");

    // R2/R3 lock
    wr(12'hC00, 0); rd_reg(12'hC00, rd); check(rd, 1, "R2 locked");
    wr(12'h000, 55); rd_reg(12'h000, rd); check(rd, 2, "R3 load ignored");
    wr(12'h008, 3); rd_reg(12'h008, rd); check(rd, 0, "R3 ctrl ignored");
    wr(12'h00C, 1); rd_reg(12'h014, rd); check(rd, 1, "R3 clear ignored");
    wr(12'hC00, 32'h1ACC_E550); rd_reg(12'hC00, rd); check(rd, 1, "R2 wrong key");
    wr(12'hC00, 32'h1ACC_E551); rd_reg(12'hC00, rd); check(rd, 0, "R2 unlocked");

    // R7 clear reloads and clears
    wr(12'h008, 1); tick_n(1);
    wr(12'h00C, 32'h0);
    rd_reg(12'h014, rd); check(rd, 0, "R7 flag cleared");
    rd_reg(12'h004, rd); check(rd, 2, "R7 count reloaded");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule